// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel that sits beside an up/down timer counter. Each clock it looks at the counter value, the count direction and a count-enable qualifier, and compares the counter against an active compare value. The result, interpreted according to one of eight output modes, drives a registered, active-high prepared level. A main output and a complementary output are then formed from that level, each with its own polarity input.

The prepared level is held as a two-state machine with states `PREP_LOW` and `PREP_HIGH`. Each mode is a named transition rule. `MODE_TIMING` holds the state. `MODE_SET` and `MODE_CLR` move to high or low on an enabled match. `MODE_TOG` flips the state on an enabled match. `MODE_FLO` and `MODE_FHI` force the low or high state. `MODE_PWM_A` and `MODE_PWM_B` select the state from the direction-aware comparison.

A configuration write loads the mode and the shadow-enable bit. A separate compare write loads the compare value. With shadowing on, the compare value is staged and moves to the active copy only on an update-event pulse.

Top module: `ocmp_channel`

## Requirements
- R1: After reset the prepared output is low, the mode is 000 (timing), shadowing is off and the active compare value is 0.
- R2: Mode 000 keeps the prepared output at its present level regardless of the counter.
- R3: Mode 001 sets the prepared output high, and mode 010 sets it low, one cycle after a cycle in which `cnt_en` is high and `cnt_val` equals the active compare value. Otherwise the level is held.
- R4: Mode 011 inverts the prepared output once for every cycle in which `cnt_en` is high and the counter equals the compare value. A cycle with `cnt_en` low never toggles it, even if the value still matches.
- R5: Mode 100 drives the prepared output low and mode 101 drives it high, one cycle later, independent of the counter and of `cnt_en`.
- R6: In mode 110 the next level is high if `cnt_down`=0 and the counter is below the compare value, or if `cnt_down`=1 and the counter is not above it. Otherwise it is low. This does not depend on `cnt_en`.
- R7: Mode 111 yields the opposite level to mode 110 for the same counter, compare value and direction.
- R8: While the registered shadow bit is 1, a compare write goes only to a staging copy. The active value takes the staging copy's value from before the edge at each `upd_evt`. The shadow bit is the one held before any configuration write in the same cycle.
- R9: While the registered shadow bit is 0, a compare write replaces the active value at that edge. It also takes priority over a simultaneous `upd_evt`.
- R10: `oc_main` equals the prepared level XOR `pol_main`. `oc_comp` equals the inverted prepared level XOR `pol_comp`. Both follow the polarity inputs combinationally.
- R11: A new mode or compare value first affects the prepared output at the clock edge after the one that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CW | Current counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| cnt_en | input | 1 | Counter running qualifier for match events |
| upd_evt | input | 1 | Update-event pulse |
| cfg_we | input | 1 | Write strobe for mode and shadow bit |
| wr_mode | input | 3 | Mode code to store |
| wr_shadow | input | 1 | Shadow-enable bit to store |
| cmp_we | input | 1 | Write strobe for the compare value |
| wr_cmp | input | CW | Compare value to store |
| pol_main | input | 1 | Polarity for the main output |
| pol_comp | input | 1 | Polarity for the complementary output |
| oc_prep | output | 1 | Active-high prepared level |
| oc_main | output | 1 | Main output |
| oc_comp | output | 1 | Complementary output |

## Verification
The prepared level is due one edge after the inputs that produce it are sampled. A stored mode or compare value acts one edge later still. Both outputs change in the same cycle as the prepared level or a polarity input. The bench drives its inputs 1 ns after an edge. At the next edge a bench model advances its own copy of the registers, and the outputs are compared 1 ns later. Every check therefore lands in the cycle in which that result is first due.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    typedef enum logic [2:0] {
        MODE_TIMING = 3'b000,
        MODE_SET    = 3'b001,
        MODE_CLR    = 3'b010,
        MODE_TOG    = 3'b011,
        MODE_FLO    = 3'b100,
        MODE_FHI    = 3'b101,
        MODE_PWM_A  = 3'b110,
        MODE_PWM_B  = 3'b111
    } oc_mode_e;

    typedef enum logic {
        PREP_LOW  = 1'b0,
        PREP_HIGH = 1'b1
    } prep_state_e;

    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
    } cmp_flags_t;

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    wr_mode,
    input  logic          wr_shadow,
    input  logic          cmp_we,
    input  logic [CW-1:0] wr_cmp,
    input  logic          upd_evt,
    output oc_mode_e      mode_q,
    output logic          shadow_q,
    output logic [CW-1:0] cmp_act
);

    localparam logic [CW-1:0] CMP_RST = '0;

    logic [CW-1:0] cmp_stage;

    // configuration: mode and shadow bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_TIMING;
            shadow_q <= 1'b0;
        end else if (cfg_we) begin
            mode_q   <= oc_mode_e'(wr_mode);
            shadow_q <= wr_shadow;
        end
    end

    // staging copy always follows writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_stage <= CMP_RST;
        end else if (cmp_we) begin
            cmp_stage <= wr_cmp;
        end
    end

    // active copy: direct write when unshadowed, else update event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_act <= CMP_RST;
        end else if (cmp_we && !shadow_q) begin
            cmp_act <= wr_cmp;
        end else if (upd_evt) begin
            cmp_act <= cmp_stage;
        end
    end

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match
    import ocmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt_val,
    input  logic [CW-1:0] cmp_act,
    output cmp_flags_t    flags
);

    always_comb begin
        flags.eq = (cnt_val == cmp_act);
        flags.lt = (cnt_val <  cmp_act);
        flags.gt = (cnt_val >  cmp_act);
    end

endmodule

// File: rtl/ocmp_prep_fsm.sv
module ocmp_prep_fsm
    import ocmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  oc_mode_e    mode,
    input  cmp_flags_t  flags,
    input  logic        cnt_en,
    input  logic        cnt_down,
    output prep_state_e state_q
);

    prep_state_e state_d;
    logic        hit;
    logic        pwm_hi;

    always_comb begin
        hit    = cnt_en && flags.eq;
        pwm_hi = cnt_down ? !flags.gt : flags.lt;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PREP_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // transition rules per mode
    always_comb begin
        state_d = state_q;
        unique case (mode)
            MODE_TIMING: state_d = state_q;
            MODE_SET:    if (hit) state_d = PREP_HIGH;
            MODE_CLR:    if (hit) state_d = PREP_LOW;
            MODE_TOG:    if (hit) state_d = (state_q == PREP_HIGH) ? PREP_LOW : PREP_HIGH;
            MODE_FLO:    state_d = PREP_LOW;
            MODE_FHI:    state_d = PREP_HIGH;
            MODE_PWM_A:  state_d = pwm_hi ? PREP_HIGH : PREP_LOW;
            MODE_PWM_B:  state_d = pwm_hi ? PREP_LOW : PREP_HIGH;
        endcase
    end

endmodule

// File: rtl/ocmp_polarity.sv
module ocmp_polarity #(
    parameter int NOUT = 2
) (
    input  logic            prep,
    input  logic [NOUT-1:0] pol,
    output logic [NOUT-1:0] outs
);

    // even index: true sense, odd index: complementary sense
    for (genvar i = 0; i < NOUT; i++) begin : g_out
        if ((i % 2) == 0) begin : g_true
            assign outs[i] = prep ^ pol[i];
        end else begin : g_inv
            assign outs[i] = ~prep ^ pol[i];
        end
    end

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_down,
    input  logic          cnt_en,
    input  logic          upd_evt,
    input  logic          cfg_we,
    input  logic [2:0]    wr_mode,
    input  logic          wr_shadow,
    input  logic          cmp_we,
    input  logic [CW-1:0] wr_cmp,
    input  logic          pol_main,
    input  logic          pol_comp,
    output logic          oc_prep,
    output logic          oc_main,
    output logic          oc_comp
);

    localparam int NOUT = 2;

    oc_mode_e      mode_q;
    logic          shadow_q;
    logic [CW-1:0] cmp_act;
    cmp_flags_t    flags;
    prep_state_e   prep_q;
    logic [NOUT-1:0] pol_vec;
    logic [NOUT-1:0] out_vec;

    ocmp_regs #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .wr_mode  (wr_mode),
        .wr_shadow(wr_shadow),
        .cmp_we   (cmp_we),
        .wr_cmp   (wr_cmp),
        .upd_evt  (upd_evt),
        .mode_q   (mode_q),
        .shadow_q (shadow_q),
        .cmp_act  (cmp_act)
    );

    ocmp_match #(.CW(CW)) u_match (
        .cnt_val(cnt_val),
        .cmp_act(cmp_act),
        .flags  (flags)
    );

    ocmp_prep_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .flags   (flags),
        .cnt_en  (cnt_en),
        .cnt_down(cnt_down),
        .state_q (prep_q)
    );

    assign pol_vec = {pol_comp, pol_main};

    ocmp_polarity #(.NOUT(NOUT)) u_pol (
        .prep(prep_q == PREP_HIGH),
        .pol (pol_vec),
        .outs(out_vec)
    );

    always_comb begin
        oc_prep = (prep_q == PREP_HIGH);
        oc_main = out_vec[0];
        oc_comp = out_vec[1];
    end

endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk
    import ocmp_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt_val,
    input logic          cnt_en,
    input logic          upd_evt,
    input logic          cmp_we,
    input logic [CW-1:0] wr_cmp,
    input logic          pol_main,
    input logic          pol_comp,
    input logic          oc_prep,
    input logic          oc_main,
    input logic          oc_comp,
    input oc_mode_e      mode_q,
    input logic          shadow_q,
    input logic [CW-1:0] cmp_act
);

    p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !oc_prep);

    p_timing_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TIMING) |=> $stable(oc_prep));

    p_toggle_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TOG && cnt_en && cnt_val == cmp_act) |=> (oc_prep != $past(oc_prep)));

    p_toggle_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TOG && !cnt_en) |=> $stable(oc_prep));

    p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FLO) |=> !oc_prep);

    p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FHI) |=> oc_prep);

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_q && !upd_evt) |=> $stable(cmp_act));

    p_direct_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && !shadow_q) |=> (cmp_act == $past(wr_cmp)));

    p_comp_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_main == pol_comp) |-> (oc_main != oc_comp));

endmodule

bind ocmp_channel ocmp_channel_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_val (cnt_val),
    .cnt_en  (cnt_en),
    .upd_evt (upd_evt),
    .cmp_we  (cmp_we),
    .wr_cmp  (wr_cmp),
    .pol_main(pol_main),
    .pol_comp(pol_comp),
    .oc_prep (oc_prep),
    .oc_main (oc_main),
    .oc_comp (oc_comp),
    .mode_q  (mode_q),
    .shadow_q(shadow_q),
    .cmp_act (cmp_act)
);

// File: tb/ocmp_channel_tb_top.sv
`timescale 1ns/1ps
module ocmp_channel_tb_top;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt_val = '0;
    logic          cnt_down = 1'b0;
    logic          cnt_en = 1'b0;
    logic          upd_evt = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    wr_mode = 3'b000;
    logic          wr_shadow = 1'b0;
    logic          cmp_we = 1'b0;
    logic [CW-1:0] wr_cmp = '0;
    logic          pol_main = 1'b0;
    logic          pol_comp = 1'b0;
    logic          oc_prep, oc_main, oc_comp;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // model state
    logic [2:0]    m_mode = 3'b000;
    logic          m_shadow = 1'b0;
    logic [CW-1:0] m_act = '0;
    logic [CW-1:0] m_stage = '0;
    logic          m_prep = 1'b0;

    always #2.5 clk = ~clk;

    ocmp_channel #(.CW(CW)) dut_i (.*);

    function automatic logic next_prep(logic [2:0] md, logic cur, logic [CW-1:0] cv,
                                       logic [CW-1:0] ca, logic en, logic dn);
        logic hit, pwm;
        hit = en && (cv == ca);
        pwm = dn ? !(cv > ca) : (cv < ca);
        case (md)
            3'd0: return cur;
            3'd1: return hit ? 1'b1 : cur;
            3'd2: return hit ? 1'b0 : cur;
            3'd3: return hit ? ~cur : cur;
            3'd4: return 1'b0;
            3'd5: return 1'b1;
            3'd6: return pwm;
            default: return ~pwm;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] md);
        case (md)
            3'd0: return "R2";
            3'd1, 3'd2: return "R3";
            3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_outs(string tag);
        check(tag, "oc_prep", oc_prep, m_prep);
        check("R10", "oc_main", oc_main, m_prep ^ pol_main);
        check("R10", "oc_comp", oc_comp, ~m_prep ^ pol_comp);
    endtask

    // one clock: advance model with pre-edge inputs, then compare
    task automatic tick(string tag);
        logic [CW-1:0] old_stage;
        @(posedge clk);
        m_prep = next_prep(m_mode, m_prep, cnt_val, m_act, cnt_en, cnt_down);
        old_stage = m_stage;
        if (cmp_we && !m_shadow) m_act = wr_cmp;
        else if (upd_evt) m_act = old_stage;
        if (cmp_we) m_stage = wr_cmp;
        if (cfg_we) begin
            m_mode = wr_mode;
            m_shadow = wr_shadow;
        end
        #1;
        check_outs(tag == "" ? tag_of(m_mode) : tag);
        cfg_we = 1'b0;
        cmp_we = 1'b0;
        upd_evt = 1'b0;
    endtask

    task automatic set_cfg(logic [2:0] md, logic sh);
        cfg_we = 1'b1; wr_mode = md; wr_shadow = sh;
        tick("R11");
    endtask

    task automatic set_cmp(logic [CW-1:0] v);
        cmp_we = 1'b1; wr_cmp = v;
        tick("R11");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #12;
        #1 check_outs("R1");
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: compare value 0 after reset: set mode hits at counter 0
        cnt_en = 1'b1; cnt_val = 0;
        tick("R1");
        set_cfg(3'd1, 1'b0);
        tick("R1");
        check("R1", "set at zero", oc_prep, 1'b1);

        // R2: timing mode holds through matches
        set_cfg(3'd0, 1'b0);
        for (int i = 0; i < 4; i++) begin cnt_val = i; tick("R2"); end

        // R5 force low / high with counter stopped
        cnt_en = 1'b0;
        set_cfg(3'd4, 1'b0); tick("R5");
        set_cfg(3'd5, 1'b0); tick("R5");

        // R3 clear on match then set on match, R9 direct write
        set_cmp(7);
        set_cfg(3'd2, 1'b0);
        cnt_en = 1'b1; cnt_val = 6; tick("R3");
        cnt_val = 7; tick("R3");
        check("R3", "clear on match", oc_prep, 1'b0);
        cnt_en = 1'b0; set_cfg(3'd1, 1'b0); cnt_val = 7; tick("R3");
        cnt_en = 1'b1; tick("R3");
        check("R3", "set on match", oc_prep, 1'b1);

        // R4 toggle, stalled cycles do not toggle
        set_cfg(3'd3, 1'b0);
        tick("R4"); tick("R4");
        cnt_en = 1'b0; tick("R4"); tick("R4"); tick("R4");
        cnt_en = 1'b1; cnt_val = 8; tick("R4");

        // R6 / R7 PWM both directions, including equality
        set_cmp(5);
        for (int md = 6; md < 8; md++) begin
            set_cfg(md[2:0], 1'b0);
            for (int d = 0; d < 2; d++) begin
                cnt_down = d[0];
                for (int v = 3; v < 8; v++) begin
                    cnt_val = v;
                    tick(md == 6 ? "R6" : "R7");
                end
            end
        end

        // R8 shadow: write held until update
        cnt_down = 1'b0;
        set_cfg(3'd6, 1'b1);
        set_cmp(2);
        cnt_val = 3; tick("R8"); tick("R8");
        check("R8", "held before update", oc_prep, 1'b1);
        upd_evt = 1'b1; cmp_we = 1'b1; wr_cmp = 9; tick("R8");
        tick("R8");
        check("R8", "old stage loaded", oc_prep, 1'b0);
        upd_evt = 1'b1; tick("R8"); tick("R8");
        check("R8", "new stage loaded", oc_prep, 1'b1);

        // R10 polarity combinations
        for (int p = 0; p < 4; p++) begin
            pol_main = p[0]; pol_comp = p[1];
            #1 check_outs("R10");
            tick("R10");
        end

        // random phase
        for (int n = 0; n < 3000; n++) begin
            cnt_en   = ($urandom % 4) != 0;
            cnt_down = $urandom % 2;
            cnt_val  = CW'($urandom % 12);
            upd_evt  = ($urandom % 8) == 0;
            if (($urandom % 16) == 0) begin
                cfg_we = 1'b1; wr_mode = 3'($urandom % 8); wr_shadow = $urandom % 2;
            end
            if (($urandom % 6) == 0) begin
                cmp_we = 1'b1; wr_cmp = CW'($urandom % 12);
            end
            if (($urandom % 50) == 0) begin
                pol_main = $urandom % 2; pol_comp = $urandom % 2;
            end
            tick("");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule